// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block derives the serial clock of an I2C master from a faster system clock. A 16-bit divider word sets the two halves of each bit period separately. The upper byte is the high-phase count and the lower byte is the low-phase count. Each phase lasts two system cycles more than its count, so the bit rate is f_clk / (4 + high + low). With 0x33 in both bytes the rate is near 100 kHz, and with a high count of 0x0A and a low count of 0x0F it is near 400 kHz.

The SCL pin is driven in open-drain fashion. The block only ever pulls the line low and otherwise releases it. It reads the real line level back so that a slave stretching the clock holds off the high phase. Two single-cycle strobes mark the middle of each low phase, where a companion byte engine changes SDA, and the middle of each high phase, where it samples SDA. Start and stop conditions, shifting and arbitration belong to that engine.

Top module: `i2c_scl_gen`

## Requirements
- R1: After asynchronous reset, and in every cycle that follows a cycle with `en` low, `scl_pull_low`, `low_mid_stb` and `high_mid_stb` are all 0.
- R2: When `en` is sampled high while the block is idle, `scl_pull_low` is 1 in the next cycle, so the first phase driven is always a low phase.
- R3: A low phase keeps `scl_pull_low` at 1 for exactly 2 + `div_cfg[7:0]` cycles.
- R4: A high phase keeps `scl_pull_low` at 0 for exactly 2 + `div_cfg[15:8]` cycles when no device stretches the line, so one bit period is 4 + high + low cycles.
- R5: `low_mid_stb` pulses for exactly one cycle in each low phase, at cycle index floor((2 + low)/2), counting the first low cycle as index 0.
- R6: `high_mid_stb` pulses for exactly one cycle in each high phase, at cycle index floor((2 + high)/2), counting from the first high cycle as index 0. Only cycles in which `scl_sense` is 1 are counted. The two strobes are never high together.
- R7: While `scl_sense` reads 0 during a high phase, the high-phase count does not advance. A stretch of S cycles therefore lengthens that high phase, and moves its strobe, by exactly S cycles.
- R8: The divider word is captured only on entry to a low phase. A write during a bit period leaves that period's low and high lengths unchanged and takes effect from the next low phase.
- R9: `srst` high returns the block to idle at the next clock edge, with the line released, even while `en` is high. After `srst` falls with `en` high, the next cycle starts a low phase.
- R10: Dropping `en` in the middle of a phase releases the line in the next cycle, and it stays released while `en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from which SCL is derived |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| srst | input | 1 | Synchronous reset back to idle |
| en | input | 1 | Run enable; low holds the block idle with SCL released |
| div_cfg | input | 16 | Divider word: [15:8] high-phase count, [7:0] low-phase count |
| scl_sense | input | 1 | Level read back from the SCL wire (1 = high) |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_mid_stb | output | 1 | One-cycle pulse at the middle of each low phase |
| high_mid_stb | output | 1 | One-cycle pulse at the middle of each high phase |

## Verification
The phase register and both phase counters change on the same clock edge. `scl_pull_low` therefore follows an enable, a synchronous reset or a disable one cycle after the edge that samples it. The strobes are decoded from the counters in the same cycle as the count they mark. All stimulus is applied on the falling clock edge and every output is sampled on a falling edge. Lengths and strobe positions are thus counted in whole cycles from the first falling edge at which a phase is visible. Each expected value comes from the requirement formulas, including the extra S cycles of a stretch and the one-period delay of a divider write.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  localparam int PH_NUM    = 2;
  localparam int PH_IDX_LO = 0;
  localparam int PH_IDX_HI = 1;

endpackage

// File: rtl/i2c_scl_phase_cnt.sv
module i2c_scl_phase_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [LEN_W-1:0] len,
  output logic             last,
  output logic             mid
);

  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] half;

  // a phase spans len + 2 counted cycles: indices 0 .. len + 1
  assign term = {1'b0, len} + CNT_W'(1);
  assign half = ({1'b0, len} + CNT_W'(2)) >> 1;

  assign last = run && (cnt_q == term);
  assign mid  = run && (cnt_q == half);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == term) cnt_d = '0;
      else               cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3 / R4: a running count never passes its terminal value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= term));

  // R7: a paused count keeps its value
  a_r7_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_scl_ctrl.sv
module i2c_scl_ctrl
  import i2c_scl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       srst,
  input  logic       low_last,
  input  logic       high_last,
  output scl_phase_e phase,
  output logic       load_div
);

  scl_phase_e ph_q;
  scl_phase_e ph_d;

  always_comb begin
    ph_d = ph_q;
    if (srst || !en) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: ph_d = PH_LOW;
        PH_LOW:  if (low_last)  ph_d = PH_HIGH;
        PH_HIGH: if (high_last) ph_d = PH_LOW;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  assign load_div = (ph_d == PH_LOW) && (ph_q != PH_LOW);
  assign phase    = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  a_r2_first_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && en && !srst) |=> (ph_q == PH_LOW));

  a_r9_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ph_q == PH_IDLE));

  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ph_q == PH_IDLE));

  a_r3_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOW && !low_last && en && !srst) |=> (ph_q == PH_LOW));

  a_r4_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIGH && !high_last && en && !srst) |=> (ph_q == PH_HIGH));

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             scl_sense,
  output logic             scl_pull_low,
  output logic             low_mid_stb,
  output logic             high_mid_stb
);

  localparam int HALF_W = DIV_W / 2;

  scl_phase_e        phase;
  logic              load_div;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_d;
  logic              ph_clr;
  logic [PH_NUM-1:0] ph_run;
  logic [PH_NUM-1:0] ph_last;
  logic [PH_NUM-1:0] ph_mid;
  logic [HALF_W-1:0] ph_len [PH_NUM];

  // divider capture, enabled only on entry to a low phase
  assign div_d = load_div ? div_cfg : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign ph_len[PH_IDX_LO] = div_q[HALF_W-1:0];
  assign ph_len[PH_IDX_HI] = div_q[DIV_W-1:HALF_W];

  assign ph_clr = srst || !en || (phase == PH_IDLE);
  assign ph_run[PH_IDX_LO] = (phase == PH_LOW);
  assign ph_run[PH_IDX_HI] = (phase == PH_HIGH) && scl_sense;

  for (genvar g = 0; g < PH_NUM; g++) begin : g_phase
    i2c_scl_phase_cnt #(.LEN_W(HALF_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ph_clr),
      .run  (ph_run[g]),
      .len  (ph_len[g]),
      .last (ph_last[g]),
      .mid  (ph_mid[g])
    );
  end

  i2c_scl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .srst     (srst),
    .low_last (ph_last[PH_IDX_LO]),
    .high_last(ph_last[PH_IDX_HI]),
    .phase    (phase),
    .load_div (load_div)
  );

  assign scl_pull_low = (phase == PH_LOW);
  assign low_mid_stb  = ph_mid[PH_IDX_LO];
  assign high_mid_stb = ph_mid[PH_IDX_HI];

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull_low && !low_mid_stb && !high_mid_stb));

  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_mid_stb, high_mid_stb}));

  a_r8_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_div |=> $stable(div_q));

endmodule

// File: tb/i2c_scl_gen_test.sv
module i2c_scl_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 5;

  logic        clk;
  logic        rst_n;
  logic        srst;
  logic        en;
  logic [15:0] div_cfg;
  logic        stretch;
  logic        scl_sense;
  logic        scl_pull_low;
  logic        low_mid_stb;
  logic        high_mid_stb;

  int checks;
  int errors;
  bit done;

  assign scl_sense = ~(scl_pull_low | stretch);

  i2c_scl_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst        (srst),
    .en          (en),
    .div_cfg     (div_cfg),
    .scl_sense   (scl_sense),
    .scl_pull_low(scl_pull_low),
    .low_mid_stb (low_mid_stb),
    .high_mid_stb(high_mid_stb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at the falling edge of the first low cycle; returns at the
  // falling edge of the first low cycle of the next period
  task automatic measure_cur(output int lo, output int hi,
                             output int lm, output int hm);
    int idx;
    lm = -1; hm = -1; idx = 0;
    while (scl_pull_low) begin
      if (low_mid_stb) lm = idx;
      idx++;
      @(negedge clk);
    end
    lo = idx; idx = 0;
    while (!scl_pull_low) begin
      if (high_mid_stb) hm = idx;
      idx++;
      @(negedge clk);
    end
    hi = idx;
  endtask

  task automatic wait_low_start();
    while (scl_pull_low)  @(negedge clk);
    while (!scl_pull_low) @(negedge clk);
  endtask

  task automatic start_run(input logic [7:0] dh, input logic [7:0] dl);
    en = 1'b0;
    repeat (2) @(negedge clk);
    div_cfg = {dh, dl};
    en = 1'b1;
    @(negedge clk);
    check_eq("R2 low phase first after enable", int'(scl_pull_low), 1);
  endtask

  task automatic test_reset();
    int seen;
    seen = 0;
    repeat (4) begin
      @(negedge clk);
      seen += int'(scl_pull_low) + int'(low_mid_stb) + int'(high_mid_stb);
    end
    check_eq("R1 outputs quiet after reset", seen, 0);
  endtask

  task automatic test_mode(input string name, input logic [7:0] dh, input logic [7:0] dl);
    int lo, hi, lm, hm;
    start_run(dh, dl);
    measure_cur(lo, hi, lm, hm);
    check_eq({"R3 low length ", name}, lo, int'(dl) + 2);
    check_eq({"R4 high length ", name}, hi, int'(dh) + 2);
    check_eq({"R5 low strobe index ", name}, lm, (int'(dl) + 2) / 2);
    check_eq({"R6 high strobe index ", name}, hm, (int'(dh) + 2) / 2);
    measure_cur(lo, hi, lm, hm);
    check_eq({"R4 period repeats ", name}, lo + hi, int'(dh) + int'(dl) + 4);
  endtask

  task automatic test_stretch();
    int lo, hi, lm, hm, idx;
    start_run(8'd4, 8'd3);
    measure_cur(lo, hi, lm, hm);
    while (scl_pull_low) @(negedge clk);
    idx = 0; hm = -1;
    while (!scl_pull_low) begin
      if (high_mid_stb) hm = idx;
      if (idx == 0) stretch = 1'b1;
      if (idx == STRETCH) stretch = 1'b0;
      idx++;
      @(negedge clk);
    end
    check_eq("R7 stretched high length", idx, STRETCH + 4 + 2);
    check_eq("R7 stretched high strobe index", hm, STRETCH + (4 + 2) / 2);
  endtask

  task automatic test_div_change();
    int lo, hi, lm, hm;
    start_run(8'd2, 8'd1);
    wait_low_start();
    div_cfg = {8'd6, 8'd9};
    measure_cur(lo, hi, lm, hm);
    check_eq("R8 current low unchanged", lo, 3);
    check_eq("R8 current high unchanged", hi, 4);
    measure_cur(lo, hi, lm, hm);
    check_eq("R8 next low uses new count", lo, 11);
    check_eq("R8 next high uses new count", hi, 8);
  endtask

  task automatic test_srst();
    int lo, hi, lm, hm, seen;
    start_run(8'd3, 8'd5);
    repeat (2) @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    check_eq("R9 line released after srst", int'(scl_pull_low), 0);
    seen = 0;
    repeat (3) begin
      @(negedge clk);
      seen += int'(scl_pull_low) + int'(low_mid_stb) + int'(high_mid_stb);
    end
    check_eq("R9 held idle during srst", seen, 0);
    srst = 1'b0;
    @(negedge clk);
    check_eq("R9 low phase after srst", int'(scl_pull_low), 1);
    measure_cur(lo, hi, lm, hm);
    check_eq("R9 full low after srst", lo, 7);
  endtask

  task automatic test_disable();
    int seen;
    start_run(8'd10, 8'd12);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_eq("R10 released after disable", int'(scl_pull_low), 0);
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      seen += int'(scl_pull_low) + int'(low_mid_stb) + int'(high_mid_stb);
    end
    check_eq("R10 R1 stays quiet while disabled", seen, 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; srst = 1'b0; en = 1'b0;
    div_cfg = '0; stretch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_mode("standard", 8'h33, 8'h33);
    test_mode("fast", 8'h0A, 8'h0F);
    test_mode("zero", 8'h00, 8'h00);
    test_mode("max", 8'hFF, 8'hFF);
    test_mode("odd", 8'h01, 8'h02);
    test_stretch();
    test_div_change();
    test_srst();
    test_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule